// File: doc/BRIEF.md
# Peripheral Power-Down and Wake-Up Controller

This block manages power for an I/O device that holds a floppy controller, two UARTs, a parallel port and an IDE interface. A small register set, together with an optional external power-down pin, selects one of four whole-chip low-power modes. Two choices define those modes: whether the oscillator is stopped or kept running, and whether the pins are tri-stated with their inputs blocked or kept driven. The same registers also switch off individual peripherals, in any combination.

The block drives an oscillator-enable output and the pin tri-state and input-block controls. It also produces a clock enable and a glitch-free gated clock for each peripheral. Whenever the oscillator is enabled, a settling counter runs from an always-on slow reference clock. Until it reaches a parameterised terminal count (about 8 ms), every peripheral clock stays off, the crystal-ready flag stays low and the floppy controller's request-for-master status bit is masked.

Top module: `io_pwr_ctrl`

## Requirements
- R1: After reset the enable register reads 5'h1F and the power, config and power-management registers read 0. `mode_o` is 0, `osc_en_o` is 1, `crystal_ready_o` is 0 and all clock enables are 0.
- R2: When `wr_en_i` is high on a rising `clk_i`, `wr_data_i` is written to the register chosen by `wr_sel_i`, and the new value takes effect in that cycle. Encoding 0 selects the enable register: bit0 parallel, bit1 UART0, bit2 UART1, bit3 floppy, bit4 IDE. Encoding 1 selects the power register: bit0 chip power-down, bit1 keep oscillator, bit2 pin option off, bit3 drive pins. Encoding 2 selects the config register, where bit6 enables the pin. Encoding 3 selects the power-management register: bit0 parallel off, bit1 both UARTs off, bit2 floppy off, bit3 IDE off, bit4 floppy low-power, bit5 UART0 low-power, bit6 UART1 low-power.
- R3: `ext_pd_i` powers the chip down only while power bit2 is 0 and config bit6 is 1. In every other case it has no effect.
- R4: With chip power-down (power bit0, or the qualified pin) active, `mode_o` is 1, 2, 3 or 4 as follows. Keep-oscillator 0 gives 1 with pins tri-stated, 2 with pins driven. Keep-oscillator 1 gives 3 tri-stated, 4 driven. Without chip power-down `mode_o` is 0.
- R5: `osc_en_o` is low in modes 1 and 2, and also whenever floppy low-power is set or both UART low-power bits are set. A single UART low-power bit does not stop the oscillator.
- R6: `pins_hiz_o` and `in_block_o` are high exactly in modes 1 and 3.
- R7: The settling count clears while `osc_en_o` is low. `crystal_ready_o` rises after `SETTLE_CYCLES` consecutive `clk_i` edges with `osc_en_o` high, and is low whenever `osc_en_o` is low.
- R8: A clock enable is high only when crystal-ready is high, chip power-down is inactive, the peripheral's enable bit is set and its off bit is clear. For the floppy and each UART, its low-power bit must also be clear.
- R9: `fdc_rqm_o` equals `fdc_rqm_i` while the floppy clock enable is high, and is 0 otherwise.
- R10: `gclk_o[k]` follows `osc_clk_i` while `clk_en_o[k]` is held high and stays low while it is held low. Its gate changes only while `osc_clk_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on slow reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select |
| wr_data_i | input | 8 | Register write data |
| ext_pd_i | input | 1 | External power-down pin, active high |
| osc_clk_i | input | 1 | Oscillator clock to be gated |
| fdc_rqm_i | input | 1 | Request-for-master from the floppy core |
| osc_en_o | output | 1 | Oscillator enable |
| pins_hiz_o | output | 1 | Tri-state the pins |
| in_block_o | output | 1 | Block the inputs |
| mode_o | output | 3 | Whole-chip mode, 0 is running |
| crystal_ready_o | output | 1 | Oscillator settled |
| clk_en_o | output | 5 | Per-peripheral clock enables |
| gclk_o | output | 5 | Per-peripheral gated clocks |
| fdc_rqm_o | output | 1 | Masked request-for-master |

## Verification
The bench walks through all four power-register mode codes and compares mode, oscillator and pin controls every cycle. A swapped decode would report a driven-pin mode while tri-stating, or would stop the oscillator in a fast-wake mode. It sets a single UART low-power bit and then both, so a design that stops the oscillator on either UART, or ignores the pair, mismatches. It also drives the external pin with its option disabled, and a design that honours the pin without qualification enters mode 1. Finally, it interrupts settling halfway and restarts it. A counter that is not cleared would raise crystal-ready, the clock enables and request-for-master too early, and a gated clock that keeps running after its enable drops would show up as high samples.

// File: rtl/io_pwr_pkg.sv
package io_pwr_pkg;
  localparam int NPERIPH = 5;
  localparam int P_PP  = 0;
  localparam int P_U0  = 1;
  localparam int P_U1  = 2;
  localparam int P_FDC = 3;
  localparam int P_IDE = 4;

  typedef enum logic [1:0] {
    SEL_EN  = 2'd0,
    SEL_PWR = 2'd1,
    SEL_CFG = 2'd2,
    SEL_PM  = 2'd3
  } reg_sel_e;

  typedef enum logic [2:0] {
    MODE_RUN  = 3'd0,
    MODE_DEEP = 3'd1, // osc off, pins hi-z
    MODE_HOLD = 3'd2, // osc off, pins driven
    MODE_PARK = 3'd3, // osc on, pins hi-z
    MODE_IDLE = 3'd4  // osc on, pins driven
  } chip_mode_e;

  typedef struct packed {
    logic drive_pins;
    logic pin_opt_off;
    logic osc_keep;
    logic chip_pd;
  } pwr_reg_t;

  typedef struct packed {
    logic u1_lp;
    logic u0_lp;
    logic fdc_lp;
    logic ide_off;
    logic fdc_off;
    logic uart_off;
    logic pp_off;
  } pm_reg_t;
endpackage

// File: rtl/io_pwr_regs.sv
module io_pwr_regs
  import io_pwr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [7:0]         wr_data_i,
  output logic [NPERIPH-1:0] en_o,
  output pwr_reg_t           pwr_o,
  output logic               pin_pd_en_o,
  output pm_reg_t            pm_o
);
  localparam int PM_W  = $bits(pm_reg_t);
  localparam int PWR_W = $bits(pwr_reg_t);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o        <= '1;
      pwr_o       <= '0;
      pin_pd_en_o <= 1'b0;
      pm_o        <= '0;
    end else if (wr_en_i) begin
      unique case (reg_sel_e'(wr_sel_i))
        SEL_EN:  en_o        <= wr_data_i[NPERIPH-1:0];
        SEL_PWR: pwr_o       <= pwr_reg_t'(wr_data_i[PWR_W-1:0]);
        SEL_CFG: pin_pd_en_o <= wr_data_i[6];
        SEL_PM:  pm_o        <= pm_reg_t'(wr_data_i[PM_W-1:0]);
        default: ;
      endcase
    end
  end

  assert_wr_en_reg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_EN) |=> en_o == $past(wr_data_i[NPERIPH-1:0]));
  assert_wr_pm_reg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_PM) |=> pm_o == $past(wr_data_i[PM_W-1:0]));
endmodule

// File: rtl/io_pwr_decode.sv
module io_pwr_decode
  import io_pwr_pkg::*;
(
  input  logic [NPERIPH-1:0] en_i,
  input  pwr_reg_t           pwr_i,
  input  logic               pin_pd_en_i,
  input  pm_reg_t            pm_i,
  input  logic               ext_pd_i,
  output logic               chip_dn_o,
  output logic               osc_en_o,
  output logic               pins_hiz_o,
  output chip_mode_e         mode_o,
  output logic [NPERIPH-1:0] want_o
);
  logic pin_act;
  logic osc_stop;

  always_comb begin
    pin_act    = !pwr_i.pin_opt_off && pin_pd_en_i && ext_pd_i;
    chip_dn_o  = pwr_i.chip_pd || pin_act;
    osc_stop   = (chip_dn_o && !pwr_i.osc_keep) || pm_i.fdc_lp || (pm_i.u0_lp && pm_i.u1_lp);
    osc_en_o   = !osc_stop;
    pins_hiz_o = chip_dn_o && !pwr_i.drive_pins;
    if (!chip_dn_o)            mode_o = MODE_RUN;
    else if (!pwr_i.osc_keep)  mode_o = pwr_i.drive_pins ? MODE_HOLD : MODE_DEEP;
    else                       mode_o = pwr_i.drive_pins ? MODE_IDLE : MODE_PARK;

    want_o        = '0;
    want_o[P_PP]  = en_i[P_PP]  && !pm_i.pp_off;
    want_o[P_U0]  = en_i[P_U0]  && !pm_i.uart_off && !pm_i.u0_lp;
    want_o[P_U1]  = en_i[P_U1]  && !pm_i.uart_off && !pm_i.u1_lp;
    want_o[P_FDC] = en_i[P_FDC] && !pm_i.fdc_off  && !pm_i.fdc_lp;
    want_o[P_IDE] = en_i[P_IDE] && !pm_i.ide_off;
  end

  always_comb begin
    if (mode_o == MODE_DEEP || mode_o == MODE_HOLD)
      assert_slow_modes_osc_off_R5: assert (!osc_en_o);
    if (pins_hiz_o)
      assert_hiz_modes_R6: assert (mode_o == MODE_DEEP || mode_o == MODE_PARK);
  end
endmodule

// File: rtl/io_pwr_settle.sv
module io_pwr_settle #(
  parameter int SETTLE_CYCLES = 262
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_en_i,
  output logic ready_o
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] TERM = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!osc_en_i)     cnt_q <= '0;
    else if (cnt_q != TERM) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = osc_en_i && (cnt_q == TERM);

  assert_cnt_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |=> cnt_q == '0);
  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TERM);
  assert_cnt_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_en_i && cnt_q != TERM) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/io_pwr_clk_gate.sv
module io_pwr_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic gclk_o
);
  logic s1_q, s2_q, en_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= en_i;
      s2_q <= s1_q;
    end
  end

  // enable moves only on the falling edge, so the AND cannot chop a high phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_lo_q <= 1'b0;
    else         en_lo_q <= s2_q;
  end

  assign gclk_o = clk_i & en_lo_q;

  assert_gate_follows_sync_R10: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $past(s2_q) |-> en_lo_q);
endmodule

// File: rtl/io_pwr_ctrl.sv
module io_pwr_ctrl
  import io_pwr_pkg::*;
#(
  parameter int SETTLE_CYCLES = 262
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [7:0]         wr_data_i,
  input  logic               ext_pd_i,
  input  logic               osc_clk_i,
  input  logic               fdc_rqm_i,
  output logic               osc_en_o,
  output logic               pins_hiz_o,
  output logic               in_block_o,
  output logic [2:0]         mode_o,
  output logic               crystal_ready_o,
  output logic [NPERIPH-1:0] clk_en_o,
  output logic [NPERIPH-1:0] gclk_o,
  output logic               fdc_rqm_o
);
  logic [NPERIPH-1:0] en_r;
  pwr_reg_t           pwr_r;
  logic               pin_pd_en_r;
  pm_reg_t            pm_r;
  logic               chip_dn;
  chip_mode_e         mode;
  logic [NPERIPH-1:0] want;

  io_pwr_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .en_o        (en_r),
    .pwr_o       (pwr_r),
    .pin_pd_en_o (pin_pd_en_r),
    .pm_o        (pm_r)
  );

  io_pwr_decode u_decode (
    .en_i        (en_r),
    .pwr_i       (pwr_r),
    .pin_pd_en_i (pin_pd_en_r),
    .pm_i        (pm_r),
    .ext_pd_i    (ext_pd_i),
    .chip_dn_o   (chip_dn),
    .osc_en_o    (osc_en_o),
    .pins_hiz_o  (pins_hiz_o),
    .mode_o      (mode),
    .want_o      (want)
  );

  io_pwr_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .osc_en_i (osc_en_o),
    .ready_o  (crystal_ready_o)
  );

  assign in_block_o = pins_hiz_o;
  assign mode_o     = mode;
  assign clk_en_o   = (crystal_ready_o && !chip_dn) ? want : '0;
  assign fdc_rqm_o  = fdc_rqm_i && clk_en_o[P_FDC];

  for (genvar k = 0; k < NPERIPH; k++) begin : g_gate
    io_pwr_clk_gate u_gate (
      .clk_i  (osc_clk_i),
      .rst_ni (rst_ni),
      .en_i   (clk_en_o[k]),
      .gclk_o (gclk_o[k])
    );
  end

  assert_ce_needs_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clk_en_o) |-> (crystal_ready_o && osc_en_o));
  assert_rqm_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fdc_rqm_o |-> clk_en_o[P_FDC]);
  assert_ready_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> !crystal_ready_o);
  assert_mode_pins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd0) |-> (!pins_hiz_o && !in_block_o));
endmodule

// File: tb/io_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module io_pwr_ctrl_tb;
  localparam int S = 12;

  logic clk_i = 0, osc_clk_i = 0, rst_ni = 0;
  logic wr_en_i = 0, ext_pd_i = 0, fdc_rqm_i = 0;
  logic [1:0] wr_sel_i = 0;
  logic [7:0] wr_data_i = 0;
  logic osc_en_o, pins_hiz_o, in_block_o, crystal_ready_o, fdc_rqm_o;
  logic [2:0] mode_o;
  logic [4:0] clk_en_o, gclk_o;

  always #2 clk_i = ~clk_i;
  always #3 osc_clk_i = ~osc_clk_i;

  io_pwr_ctrl #(.SETTLE_CYCLES(S)) u_dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference state
  logic [4:0] m_en;
  logic [3:0] m_pw;
  logic       m_cfg;
  logic [6:0] m_pm;
  int         m_cnt;

  function automatic bit f_chip_dn();
    return m_pw[0] || (!m_pw[2] && m_cfg && ext_pd_i);
  endfunction
  function automatic bit f_osc();
    return !((f_chip_dn() && !m_pw[1]) || m_pm[4] || (m_pm[5] && m_pm[6]));
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en <= 5'h1F; m_pw <= 0; m_cfg <= 0; m_pm <= 0; m_cnt <= 0;
    end else begin
      if (!f_osc()) m_cnt <= 0;
      else if (m_cnt < S) m_cnt <= m_cnt + 1;
      if (wr_en_i) case (wr_sel_i)
        2'd0: m_en  <= wr_data_i[4:0];
        2'd1: m_pw  <= wr_data_i[3:0];
        2'd2: m_cfg <= wr_data_i[6];
        default: m_pm <= wr_data_i[6:0];
      endcase
    end
  end

  always @(negedge clk_i) if (!done) begin
    bit dn, osc, rdy, hiz;
    int md;
    logic [4:0] ce;
    dn  = f_chip_dn();
    osc = f_osc();
    rdy = osc && (m_cnt == S);
    hiz = dn && !m_pw[3];
    md  = !dn ? 0 : (!m_pw[1] ? (m_pw[3] ? 2 : 1) : (m_pw[3] ? 4 : 3));
    ce = 0;
    if (rdy && !dn) begin
      ce[0] = m_en[0] && !m_pm[0];
      ce[1] = m_en[1] && !m_pm[1] && !m_pm[5];
      ce[2] = m_en[2] && !m_pm[1] && !m_pm[6];
      ce[3] = m_en[3] && !m_pm[2] && !m_pm[4];
      ce[4] = m_en[4] && !m_pm[3];
    end
    chk("R4 mode_o", mode_o, md);
    chk("R5 osc_en_o", osc_en_o, osc);
    chk("R6 pins_hiz_o", pins_hiz_o, hiz);
    chk("R6 in_block_o", in_block_o, hiz);
    chk("R7 crystal_ready_o", crystal_ready_o, rdy);
    chk("R8 clk_en_o", clk_en_o, ce);
    chk("R9 fdc_rqm_o", fdc_rqm_o, fdc_rqm_i && ce[3]);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask
  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk_i); #1;
    wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i); #1;
    wr_en_i = 0;
  endtask
  task automatic gclk_chk(int k, bit on);
    repeat (6) @(posedge osc_clk_i);
    for (int i = 0; i < 4; i++) begin
      @(posedge osc_clk_i); #1;
      chk("R10 gclk_o high phase", gclk_o[k], on);
      @(negedge osc_clk_i); #1;
      chk("R10 gclk_o low phase", gclk_o[k], 0);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    fdc_rqm_i = 1;
    cyc(3);
    chk("R1 reset ready low", crystal_ready_o, 0);
    chk("R1 reset osc on", osc_en_o, 1);
    rst_ni = 1;
    cyc(S - 2);
    chk("R7 not ready before count", crystal_ready_o, 0);
    cyc(4);
    chk("R1 reset enables all on", clk_en_o, 5'h1F);
    // enable register patterns
    wr(0, 8'h0A); cyc(2);
    chk("R2 enable write", clk_en_o, 5'h0A);
    wr(0, 8'h15); cyc(2);
    wr(0, 8'h1F);
    // per-peripheral off combos
    wr(3, 8'h05); cyc(2);
    wr(3, 8'h0A); cyc(2);
    fdc_rqm_i = 0; cyc(2); fdc_rqm_i = 1;
    wr(3, 8'h00); cyc(2);
    // single UART low-power keeps oscillator, both stop it
    wr(3, 8'h20); cyc(3);
    chk("R5 one uart lp osc on", osc_en_o, 1);
    wr(3, 8'h60); cyc(3);
    chk("R5 both uart lp osc off", osc_en_o, 0);
    wr(3, 8'h00); cyc(S / 2);
    wr(3, 8'h10); cyc(3);  // interrupt settling
    wr(3, 8'h00); cyc(S + 4);
    // four whole-chip modes
    wr(1, 8'h01); cyc(4); wr(1, 8'h00); cyc(S + 3);
    wr(1, 8'h09); cyc(4); wr(1, 8'h00); cyc(S + 3);
    wr(1, 8'h03); cyc(4);
    chk("R4 mode 3", mode_o, 3);
    wr(1, 8'h0B); cyc(4);
    chk("R4 mode 4", mode_o, 4);
    wr(1, 8'h00); cyc(4);
    // pin qualification
    ext_pd_i = 1; cyc(3);
    chk("R3 pin ignored without cfg", mode_o, 0);
    wr(2, 8'h40); cyc(3);
    chk("R3 pin active", mode_o, 1);
    wr(1, 8'h04); cyc(3);
    chk("R3 pin ignored with option off", mode_o, 0);
    cyc(S + 3);
    ext_pd_i = 0; wr(1, 8'h00); wr(2, 8'h00); cyc(S + 3);
    // gated clocks
    gclk_chk(3, 1);
    wr(3, 8'h04);
    gclk_chk(3, 0);
    gclk_chk(0, 1);
    wr(3, 8'h00); cyc(4);
    finish_run();
  end
endmodule